// File: doc/BRIEF.md
# Flash Command Sequence Generator

This block sits on the host side of a parallel NOR flash and turns one high-level request into the series of bus writes the flash expects. A request names an operation, a sector base, a target word address, a data word and a word count. The block takes it over a ready/valid handshake and issues each bus write through an internal timer. The timer sets up the address and data, pulses an active-low write strobe, and holds the bus before the next write starts. Unlock pairs come first in every sequence except the software reset. Buffered programming draws its address/data pairs from a separate ready/valid word stream, one pair per load write.

The block never reads the flash. When the last write of a sequence has finished its hold time, it raises a one-cycle completion pulse so that a separate status poller can take over. A request that cannot be issued is refused with a one-cycle error pulse and causes no bus activity.

Operation codes on `req_op`: 0 = single-word program, 1 = chip erase, 2 = sector erase, 3 = buffered program, 4 = software reset; 5 to 7 are invalid. Defaults: 22-bit word address, 16-bit data, 32-word buffer, 2 setup clocks, 3 strobe clocks, 2 hold clocks. Command bytes are zero-extended to the data width. Unlock addresses 555h and 2AAh are zero-extended to the address width.

Top module: `nor_cmd_seq`

## Requirements
- R1: Every accepted request other than software reset begins with two writes: 555h/AAh, then 2AAh/55h.
- R2: Op code 0 issues exactly four writes: the two unlocks, then 555h/A0h, then `req_data` to `req_addr`.
- R3: Op code 1 issues exactly six writes: the two unlocks, 555h/80h, the two unlocks again, then 555h/10h.
- R4: Op code 2 issues the same first five writes as R3, then a sixth write of 30h to `req_sector`.
- R5: Op code 3 issues the two unlocks, then 25h to `req_sector`, then `req_count`-1 to `req_sector`. It then issues one load write per word-stream pair, taken in arrival order. Each pair decrements the remaining count even if its address repeats an earlier one. A final write of 29h to `req_sector` follows the last load.
- R6: While `wd_valid` is low during the load phase, no further bus write starts. `wd_ready` is high only while a load write is waiting to start.
- R7: Op code 4 issues exactly one write, F0h to address 0.
- R8: A buffered request with `req_count` of 0 or above the buffer size, or any op code from 5 to 7, is refused. `err` pulses for one cycle, `done` stays low, and no bus write occurs.
- R9: `bus_we_n` stays low for exactly the configured strobe clocks. `bus_addr` and `bus_data` stay stable from at least one clock before the strobe falls until it rises.
- R10: `done` is a single-cycle pulse, raised once per accepted valid request after the hold time of its last write.
- R11: `req_ready` is low from acceptance of a valid request until its `done` pulse. It stays high for a refused request.
- R12: After reset, `req_ready` is high, `bus_we_n` is high, and `done` and `err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Engine idle, request taken on this edge if offered |
| req_op | input | 3 | Operation code |
| req_sector | input | AW | Sector base word address |
| req_addr | input | AW | Target word address for single program |
| req_data | input | DW | Data word for single program |
| req_count | input | CW | Buffered word count |
| wd_valid | input | 1 | Word-stream pair offered |
| wd_ready | output | 1 | Load write waiting for a pair |
| wd_addr | input | AW | Word-stream address |
| wd_data | input | DW | Word-stream data |
| bus_addr | output | AW | Flash address bus |
| bus_data | output | DW | Flash write data bus |
| bus_we_n | output | 1 | Active-low write strobe |
| done | output | 1 | Sequence complete pulse |
| err | output | 1 | Request refused pulse |

## Verification
The hardest case to reach is a buffered program whose word stream runs dry partway through the load phase. The stimulus holds `wd_valid` low from the moment the request is taken. It then confirms that only the four header writes appear over a long idle window, and only after that releases the stream. Repeated addresses come from a stream that presents each address twice. A full-size buffer, a one-word buffer, and counts just outside the legal range cover the pair-counter limits.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;

  typedef enum logic [2:0] {
    OP_PROG  = 3'd0,
    OP_CHIP  = 3'd1,
    OP_SECT  = 3'd2,
    OP_BUF   = 3'd3,
    OP_RST   = 3'd4
  } op_e;

  localparam logic [11:0] ADR_UNLK_A = 12'h555;
  localparam logic [11:0] ADR_UNLK_B = 12'h2AA;

  localparam logic [7:0] CMD_KEY_A   = 8'hAA;
  localparam logic [7:0] CMD_KEY_B   = 8'h55;
  localparam logic [7:0] CMD_ERS_SET = 8'h80;
  localparam logic [7:0] CMD_ERS_ALL = 8'h10;
  localparam logic [7:0] CMD_ERS_SEC = 8'h30;
  localparam logic [7:0] CMD_PGM     = 8'hA0;
  localparam logic [7:0] CMD_BUF_LD  = 8'h25;
  localparam logic [7:0] CMD_BUF_GO  = 8'h29;
  localparam logic [7:0] CMD_RESET   = 8'hF0;

endpackage

// File: rtl/nor_req_check.sv
module nor_req_check #(
  parameter int BUF_WORDS = 32,
  parameter int CW        = 6
) (
  input  logic [2:0]    op,
  input  logic [CW-1:0] count,
  output logic          ok
);
  import nor_cmd_pkg::*;

  logic op_known;
  logic cnt_fits;

  always_comb begin
    op_known = (op <= 3'(OP_RST));
    cnt_fits = (count != '0) && (int'(count) <= BUF_WORDS);
    ok       = op_known && ((op != 3'(OP_BUF)) || cnt_fits);
  end

endmodule

// File: rtl/nor_step_gen.sv
module nor_step_gen #(
  parameter int AW = 22,
  parameter int DW = 16
) (
  input  logic [2:0]    op,
  input  logic [2:0]    idx,
  input  logic [AW-1:0] sector,
  input  logic [AW-1:0] taddr,
  input  logic [DW-1:0] tdata,
  input  logic [DW-1:0] cnt_m1,
  input  logic [AW-1:0] ld_addr,
  input  logic [DW-1:0] ld_data,
  output logic [AW-1:0] s_addr,
  output logic [DW-1:0] s_data,
  output logic          s_last,
  output logic          s_load
);
  import nor_cmd_pkg::*;

  localparam logic [AW-1:0] UA = AW'(ADR_UNLK_A);
  localparam logic [AW-1:0] UB = AW'(ADR_UNLK_B);

  always_comb begin
    s_addr = '0;
    s_data = '0;
    s_last = 1'b0;
    s_load = 1'b0;
    if (op == 3'(OP_RST)) begin
      s_data = DW'(CMD_RESET);
      s_last = 1'b1;
    end else begin
      case (idx)
        3'd0: begin s_addr = UA; s_data = DW'(CMD_KEY_A); end
        3'd1: begin s_addr = UB; s_data = DW'(CMD_KEY_B); end
        3'd2: begin
          if (op == 3'(OP_PROG)) begin
            s_addr = UA; s_data = DW'(CMD_PGM);
          end else if (op == 3'(OP_BUF)) begin
            s_addr = sector; s_data = DW'(CMD_BUF_LD);
          end else begin
            s_addr = UA; s_data = DW'(CMD_ERS_SET);
          end
        end
        3'd3: begin
          if (op == 3'(OP_PROG)) begin
            s_addr = taddr; s_data = tdata; s_last = 1'b1;
          end else if (op == 3'(OP_BUF)) begin
            s_addr = sector; s_data = cnt_m1;
          end else begin
            s_addr = UA; s_data = DW'(CMD_KEY_A);
          end
        end
        3'd4: begin
          if (op == 3'(OP_BUF)) begin
            s_addr = ld_addr; s_data = ld_data; s_load = 1'b1;
          end else begin
            s_addr = UB; s_data = DW'(CMD_KEY_B);
          end
        end
        default: begin
          s_last = 1'b1;
          if (op == 3'(OP_CHIP)) begin
            s_addr = UA; s_data = DW'(CMD_ERS_ALL);
          end else if (op == 3'(OP_SECT)) begin
            s_addr = sector; s_data = DW'(CMD_ERS_SEC);
          end else begin
            s_addr = sector; s_data = DW'(CMD_BUF_GO);
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/nor_bus_timer.sv
module nor_bus_timer #(
  parameter int AW         = 22,
  parameter int DW         = 16,
  parameter int SETUP_CLKS = 2,
  parameter int PULSE_CLKS = 3,
  parameter int HOLD_CLKS  = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic [AW-1:0] w_addr,
  input  logic [DW-1:0] w_data,
  output logic          w_done,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_data,
  output logic          bus_we_n
);
  localparam int TW = $clog2(SETUP_CLKS + PULSE_CLKS + HOLD_CLKS + 1);

  typedef enum logic [1:0] {T_IDLE, T_SETUP, T_PULSE, T_HOLD} tstate_e;

  tstate_e       st;
  logic [TW-1:0] cnt;

  initial begin
    if (SETUP_CLKS < 1 || PULSE_CLKS < 1 || HOLD_CLKS < 1)
      $error("timer phase lengths must be at least one clock");
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= T_IDLE;
      cnt      <= '0;
      w_done   <= 1'b0;
      bus_addr <= '0;
      bus_data <= '0;
      bus_we_n <= 1'b1;
    end else begin
      w_done <= 1'b0;
      case (st)
        T_IDLE: if (go) begin
          bus_addr <= w_addr;
          bus_data <= w_data;
          cnt      <= TW'(SETUP_CLKS - 1);
          st       <= T_SETUP;
        end
        T_SETUP: if (cnt == '0) begin
          bus_we_n <= 1'b0;
          cnt      <= TW'(PULSE_CLKS - 1);
          st       <= T_PULSE;
        end else cnt <= cnt - 1'b1;
        T_PULSE: if (cnt == '0) begin
          bus_we_n <= 1'b1;
          cnt      <= TW'(HOLD_CLKS - 1);
          st       <= T_HOLD;
        end else cnt <= cnt - 1'b1;
        default: if (cnt == '0) begin
          w_done <= 1'b1;
          st     <= T_IDLE;
        end else cnt <= cnt - 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq #(
  parameter int AW         = 22,
  parameter int DW         = 16,
  parameter int BUF_WORDS  = 32,
  parameter int SETUP_CLKS = 2,
  parameter int PULSE_CLKS = 3,
  parameter int HOLD_CLKS  = 2,
  localparam int CW        = $clog2(BUF_WORDS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [2:0]    req_op,
  input  logic [AW-1:0] req_sector,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  input  logic [CW-1:0] req_count,
  input  logic          wd_valid,
  output logic          wd_ready,
  input  logic [AW-1:0] wd_addr,
  input  logic [DW-1:0] wd_data,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_data,
  output logic          bus_we_n,
  output logic          done,
  output logic          err
);
  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} sstate_e;

  sstate_e       st;
  logic [2:0]    op_q;
  logic [2:0]    idx_q;
  logic [AW-1:0] sec_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] left_q;
  logic          last_q;
  logic          load_q;

  logic          req_ok;
  logic [AW-1:0] s_addr;
  logic [DW-1:0] s_data;
  logic          s_last;
  logic          s_load;
  logic          tmr_go;
  logic          tmr_done;

  nor_req_check #(.BUF_WORDS(BUF_WORDS), .CW(CW)) u_chk_req (
    .op    (req_op),
    .count (req_count),
    .ok    (req_ok)
  );

  nor_step_gen #(.AW(AW), .DW(DW)) u_step (
    .op      (op_q),
    .idx     (idx_q),
    .sector  (sec_q),
    .taddr   (addr_q),
    .tdata   (data_q),
    .cnt_m1  (DW'(cnt_q - 1'b1)),
    .ld_addr (wd_addr),
    .ld_data (wd_data),
    .s_addr  (s_addr),
    .s_data  (s_data),
    .s_last  (s_last),
    .s_load  (s_load)
  );

  nor_bus_timer #(
    .AW(AW), .DW(DW),
    .SETUP_CLKS(SETUP_CLKS), .PULSE_CLKS(PULSE_CLKS), .HOLD_CLKS(HOLD_CLKS)
  ) u_tmr (
    .clk      (clk),
    .rst      (rst),
    .go       (tmr_go),
    .w_addr   (s_addr),
    .w_data   (s_data),
    .w_done   (tmr_done),
    .bus_addr (bus_addr),
    .bus_data (bus_data),
    .bus_we_n (bus_we_n)
  );

  assign req_ready = (st == S_IDLE);
  assign wd_ready  = (st == S_ISSUE) && s_load;
  assign tmr_go    = (st == S_ISSUE) && (!s_load || wd_valid);

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= S_IDLE;
      op_q   <= '0;
      idx_q  <= '0;
      sec_q  <= '0;
      addr_q <= '0;
      data_q <= '0;
      cnt_q  <= '0;
      left_q <= '0;
      last_q <= 1'b0;
      load_q <= 1'b0;
      done   <= 1'b0;
      err    <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          if (req_ok) begin
            op_q   <= req_op;
            sec_q  <= req_sector;
            addr_q <= req_addr;
            data_q <= req_data;
            cnt_q  <= req_count;
            left_q <= req_count;
            idx_q  <= '0;
            st     <= S_ISSUE;
          end else begin
            err <= 1'b1;
          end
        end
        S_ISSUE: if (tmr_go) begin
          last_q <= s_last;
          load_q <= s_load;
          st     <= S_WAIT;
        end
        default: if (tmr_done) begin
          if (last_q) begin
            done <= 1'b1;
            st   <= S_IDLE;
          end else begin
            if (load_q) begin
              left_q <= left_q - 1'b1;
              if (left_q == CW'(1)) idx_q <= idx_q + 1'b1;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
            st <= S_ISSUE;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/nor_cmd_seq_chk.sv
module nor_cmd_seq_chk #(
  parameter int AW         = 22,
  parameter int DW         = 16,
  parameter int PULSE_CLKS = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic          req_ready,
  input logic          wd_ready,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_data,
  input logic          bus_we_n,
  input logic          done,
  input logic          err
);
  logic [15:0] low_run;

  always_ff @(posedge clk) begin
    if (rst)           low_run <= '0;
    else if (bus_we_n) low_run <= '0;
    else               low_run <= low_run + 1'b1;
  end

  // R9
  strobe_width_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_we_n) |-> (low_run == 16'(PULSE_CLKS)));

  // R9
  setup_stable_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_we_n) |-> ($stable(bus_addr) && $stable(bus_data)));

  // R9
  pulse_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!bus_we_n && $past(!bus_we_n)) |-> ($stable(bus_addr) && $stable(bus_data)));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8
  err_cause_chk: assert property (@(posedge clk) disable iff (rst)
    err |-> $past(req_valid && req_ready));

  // R8
  err_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(err && done));

  // R11
  busy_ready_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_we_n |-> !req_ready);

  // R6
  wd_idle_chk: assert property (@(posedge clk) disable iff (rst)
    wd_ready |-> !req_ready);

endmodule

bind nor_cmd_seq nor_cmd_seq_chk #(.AW(AW), .DW(DW), .PULSE_CLKS(PULSE_CLKS)) u_seq_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .wd_ready  (wd_ready),
  .bus_addr  (bus_addr),
  .bus_data  (bus_data),
  .bus_we_n  (bus_we_n),
  .done      (done),
  .err       (err)
);

// File: tb/sim_nor_cmd_seq.sv
module sim_nor_cmd_seq;
  localparam int AW = 22;
  localparam int DW = 16;
  localparam int BW = 32;
  localparam int CW = 6;
  localparam int PW = 3;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst;
  logic          req_valid, req_ready;
  logic [2:0]    req_op;
  logic [AW-1:0] req_sector, req_addr;
  logic [DW-1:0] req_data;
  logic [CW-1:0] req_count;
  logic          wd_valid, wd_ready;
  logic [AW-1:0] wd_addr;
  logic [DW-1:0] wd_data;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_data;
  logic          bus_we_n, done, err;

  nor_cmd_seq u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_sector(req_sector), .req_addr(req_addr),
    .req_data(req_data), .req_count(req_count), .wd_valid(wd_valid),
    .wd_ready(wd_ready), .wd_addr(wd_addr), .wd_data(wd_data),
    .bus_addr(bus_addr), .bus_data(bus_data), .bus_we_n(bus_we_n),
    .done(done), .err(err)
  );

  int checks = 0;
  int fails  = 0;

  // word stream: each address presented twice, data tagged by index
  logic          wd_en;
  int            wd_k;
  logic [AW-1:0] cur_addr;
  logic [DW-1:0] cur_data;
  assign wd_valid = wd_en;
  assign wd_addr  = cur_addr + AW'(wd_k >> 1);
  assign wd_data  = cur_data ^ DW'(wd_k);

  always @(posedge clk) begin
    if (req_valid && req_ready) wd_k <= 0;
    else if (wd_valid && wd_ready) wd_k <= wd_k + 1;
  end

  // bus monitor
  logic [AW-1:0] cap_a [0:511];
  logic [DW-1:0] cap_d [0:511];
  int cap_n = 0, bad_w = 0, done_n = 0, err_n = 0, low_n = 0;
  logic prev_we = 1'b1;

  always @(negedge clk) begin
    if (!rst) begin
      if (!bus_we_n && prev_we) begin
        cap_a[cap_n % 512] = bus_addr;
        cap_d[cap_n % 512] = bus_data;
        cap_n = cap_n + 1;
        low_n = 1;
      end else if (!bus_we_n) begin
        low_n = low_n + 1;
      end
      if (bus_we_n && !prev_we && low_n != PW) bad_w = bad_w + 1;
      prev_we = bus_we_n;
      if (done) done_n = done_n + 1;
      if (err)  err_n  = err_n + 1;
    end
  end

  task automatic chk(input string rq, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  // expected sequence, built from the requirements
  logic [AW-1:0] exp_a [0:63];
  logic [DW-1:0] exp_d [0:63];
  int exp_n;

  task automatic push(input logic [AW-1:0] a, input logic [DW-1:0] d);
    exp_a[exp_n] = a; exp_d[exp_n] = d; exp_n++;
  endtask

  task automatic build(input logic [2:0] op, input logic [AW-1:0] sec,
                       input logic [AW-1:0] ad, input logic [DW-1:0] dt, input int cnt);
    exp_n = 0;
    if (op == 3'd4) begin
      push('0, 16'hF0);
      return;
    end
    push(22'h555, 16'hAA); push(22'h2AA, 16'h55);
    case (op)
      3'd0: begin push(22'h555, 16'hA0); push(ad, dt); end
      3'd1: begin push(22'h555, 16'h80); push(22'h555, 16'hAA);
                  push(22'h2AA, 16'h55); push(22'h555, 16'h10); end
      3'd2: begin push(22'h555, 16'h80); push(22'h555, 16'hAA);
                  push(22'h2AA, 16'h55); push(sec, 16'h30); end
      default: begin
        push(sec, 16'h25); push(sec, DW'(cnt - 1));
        for (int k = 0; k < cnt; k++) push(ad + AW'(k >> 1), dt ^ DW'(k));
        push(sec, 16'h29);
      end
    endcase
  endtask

  function automatic string tag_of(input logic [2:0] op);
    case (op)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      default: return "R7";
    endcase
  endfunction

  task automatic run_req(input logic [2:0] op, input logic [AW-1:0] sec,
                         input logic [AW-1:0] ad, input logic [DW-1:0] dt,
                         input int cnt, input bit bad, input bit stall);
    int base, d0, e0, w0, waited, mism;
    base = cap_n; d0 = done_n; e0 = err_n; w0 = bad_w;
    build(op, sec, ad, dt, cnt);
    cur_addr = ad; cur_data = dt;
    wd_en = !stall;
    req_op = op; req_sector = sec; req_addr = ad; req_data = dt;
    req_count = CW'(cnt);
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    // R11: ready drops for an accepted request, stays up for a refused one
    chk("R11", "req_ready after accept", req_ready, bad);
    if (stall) begin
      repeat (150) @(negedge clk);
      chk("R6", "writes while stream idle", cap_n - base, 4);
      wd_en = 1'b1;
    end
    waited = 0;
    while (done_n == d0 && err_n == e0 && waited < 5000) begin
      @(negedge clk); waited++;
    end
    if (waited >= 5000) chk("R10", "sequence timeout", 1, 0);
    repeat (4) @(negedge clk);
    if (bad) begin
      chk("R8", "err pulses", err_n - e0, 1);
      chk("R8", "bus writes on refusal", cap_n - base, 0);
      chk("R8", "done on refusal", done_n - d0, 0);
    end else begin
      chk(tag_of(op), "write count", cap_n - base, exp_n);
      mism = 0;
      for (int i = 0; i < exp_n && i < cap_n - base; i++) begin
        if (cap_a[(base + i) % 512] !== exp_a[i] || cap_d[(base + i) % 512] !== exp_d[i]) begin
          if (mism == 0)
            $display("FAIL %s write %0d: actual %0h/%0h expected %0h/%0h", tag_of(op), i,
                     cap_a[(base + i) % 512], cap_d[(base + i) % 512], exp_a[i], exp_d[i]);
          mism++;
        end
      end
      checks++;
      if (mism != 0) fails++;
      if (op != 3'd4 && cap_n - base >= 2)
        chk("R1", "unlock prefix", {cap_a[base % 512], cap_d[base % 512],
            cap_a[(base + 1) % 512], cap_d[(base + 1) % 512]},
            {22'h555, 16'hAA, 22'h2AA, 16'h55});
      chk("R9", "strobe width errors", bad_w - w0, 0);
      chk("R10", "done pulses", done_n - d0, 1);
      chk("R8", "err on valid request", err_n - e0, 0);
    end
  endtask

  // op, sector, addr, data, count
  localparam logic [68:0] VEC [0:7] = '{
    {3'd0, 22'h000000, 22'h012345, 16'hBEEF, 6'd0},
    {3'd1, 22'h000000, 22'h000000, 16'h0000, 6'd0},
    {3'd2, 22'h3F8000, 22'h000000, 16'h0000, 6'd0},
    {3'd3, 22'h010000, 22'h010010, 16'h1234, 6'd1},
    {3'd3, 22'h020000, 22'h020040, 16'hA5A5, 6'd5},
    {3'd3, 22'h3F0000, 22'h3F0100, 16'h0F0F, 6'd32},
    {3'd4, 22'h000000, 22'h000000, 16'h0000, 6'd0},
    {3'd0, 22'h000000, 22'h3FFFFF, 16'h0001, 6'd0}
  };

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual expired expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_op = '0; req_sector = '0; req_addr = '0;
    req_data = '0; req_count = '0; wd_en = 1'b1; cur_addr = '0; cur_data = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12
    chk("R12", "req_ready", req_ready, 1);
    chk("R12", "bus_we_n", bus_we_n, 1);
    chk("R12", "done/err", {done, err}, 0);

    for (int v = 0; v < 8; v++)
      run_req(VEC[v][68:66], VEC[v][65:44], VEC[v][43:22], VEC[v][21:6],
              int'(VEC[v][5:0]), 1'b0, 1'b0);

    // R8: refusals
    run_req(3'd5, '0, '0, '0, 0, 1'b1, 1'b0);
    run_req(3'd7, '0, '0, '0, 0, 1'b1, 1'b0);
    run_req(3'd3, 22'h010000, 22'h010000, 16'h0, 0, 1'b1, 1'b0);
    run_req(3'd3, 22'h010000, 22'h010000, 16'h0, 33, 1'b1, 1'b0);

    // R6: stalled word stream, then R5 completion
    run_req(3'd3, 22'h230000, 22'h230008, 16'h5A00, 4, 1'b0, 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule